// File: doc/BRIEF.md
# Debounced Input Change Detector with Masked Interrupt

This block watches one asynchronous input line and reports when the line settles at a new level. The line first passes through a two-flop synchronizer. After that it is examined only on a slow sample enable, nominally a 38.4 kHz tick derived from a 3.6864 MHz system clock. A new level is accepted only when two consecutive samples agree on it. Any accepted transition, rising or falling, sets a sticky change flag. The flag stays set until the CPU clears it with a command.

The change flag sits in an interrupt status word next to five event levels that other logic supplies. Those five events are: transmitter ready, transmitter empty, receiver ready or full, break change, and counter ready. The status word always shows every raw condition. A CPU-writable mask selects which status bits may pull the single active-low interrupt line low. The interrupt line is registered. The detector can be switched off when the input is configured for a function that does not use it. While switched off, the line is still tracked but no event is raised.

Top module: `chg_irq_unit`

## Requirements
- R1: After reset, `irq_n` is 1, the change flag (status bit 5) is 0, `pin_level` is 1 and the mask is all zeros, so no event can assert the interrupt.
- R2: A falling input is accepted only on the second consecutive `sample_tick` that sees it low. The change flag and `pin_level` then update on that tick's clock edge. Without ticks, nothing is accepted however long the input stays low.
- R3: A rising input that is seen high on two consecutive ticks also sets the change flag, and `pin_level` goes to 1.
- R4: A level that is seen on only one tick, with the line back at the old level on the next tick, is rejected: the flag stays 0 and `pin_level` is unchanged.
- R5: Once set, the change flag holds until a one-cycle `clr_chg` pulse, which clears it on that cycle's clock edge.
- R6: If an accepted change and `clr_chg` fall on the same cycle, the flag ends up set.
- R7: While `det_en` is 0, accepted transitions update `pin_level` but never set the change flag. Raising `det_en` afterwards raises no stale event.
- R8: `status` is {change flag, evt_in[4:0]} for every mask value. The order of `evt_in` from bit 0 is: transmitter ready, transmitter empty, receiver ready/full, break change, counter ready.
- R9: `irq_n` is a register that is 0 exactly when the previous cycle had some status bit set together with its mask bit. A `mask_wr` takes effect in the mask on its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Slow sample enable, one cycle wide |
| pin_async | input | 1 | Asynchronous monitored input |
| det_en | input | 1 | Detector enabled by the pin's configured function |
| clr_chg | input | 1 | Command pulse clearing the change flag |
| evt_in | input | 5 | Raw levels of the other interrupt events |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 6 | Mask value, same bit order as status |
| status | output | 6 | Unmasked interrupt status word |
| irq_n | output | 1 | Registered active-low interrupt |
| pin_level | output | 1 | Debounced accepted level of the input |

## Verification
A pin change reaches the synchronizer output two clocks after it is driven. The first tick after that only records the sample. The change flag and `pin_level` are due on the clock edge of the second tick, so the bench checks both just after the first tick (expecting no change) and just after the second. `status` follows `evt_in` combinationally. `irq_n` follows one edge behind the status and mask pair, and a mask write adds one more edge. The sweep therefore waits two edges after each mask write before comparing. A separate probe, taken one nanosecond after an event is raised, confirms that `irq_n` has not yet moved.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

    localparam int NUM_EVT = 5;
    localparam int STAT_W  = NUM_EVT + 1;

    // Bit positions inside the status word
    typedef enum int {
        ST_TX_READY   = 0,
        ST_TX_EMPTY   = 1,
        ST_RX_READY   = 2,
        ST_BRK_CHANGE = 3,
        ST_CNT_READY  = 4,
        ST_PIN_CHANGE = 5
    } stat_bit_e;

    // Debounce state: last raw sample and accepted level
    typedef struct packed {
        logic smp;
        logic lvl;
    } det_state_t;

    function automatic logic any_hit(input logic [STAT_W-1:0] st,
                                     input logic [STAT_W-1:0] msk);
        return |(st & msk);
    endfunction

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/chg_debounce.sv
module chg_debounce
    import chg_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en,
    input  logic d,
    input  logic clr,
    output logic level,
    output logic chg
);
    det_state_t st;
    logic       accept;

    // New level must match the previous sample and differ from accepted level
    assign accept = tick && (d == st.smp) && (d != st.lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '{smp: 1'b1, lvl: 1'b1};
            chg <= 1'b0;
        end else begin
            if (tick)   st.smp <= d;
            if (accept) st.lvl <= d;
            if (accept && en) chg <= 1'b1;
            else if (clr)     chg <= 1'b0;
        end
    end

    assign level = st.lvl;

    // R2: accepted level moves only on a sample tick
    a_r2_level_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(st.lvl) |-> $past(tick));

    // R4: a new level was present on two consecutive samples
    a_r4_two_samples: assert property (@(posedge clk) disable iff (rst)
        !$stable(st.lvl) |-> ($past(st.smp) == st.lvl) && (st.smp == st.lvl));

    // R5: flag holds without a clear
    a_r5_chg_hold: assert property (@(posedge clk) disable iff (rst)
        (chg && !clr) |=> chg);

    // R6: an accepted change wins over a simultaneous clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (accept && en && clr) |=> chg);

    // R7: no event raised while the detector is disabled
    a_r7_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
        $rose(chg) |-> $past(en));
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
    import chg_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] status,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic              irq_n
);
    logic [STAT_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= !any_hit(status, mask_q);
    end

    // R9: enabled active condition pulls the line low one edge later
    a_r9_irq_asserts: assert property (@(posedge clk) disable iff (rst)
        (|(status & mask_q)) |=> !irq_n);

    // R9: no enabled condition releases the line one edge later
    a_r9_irq_releases: assert property (@(posedge clk) disable iff (rst)
        !(|(status & mask_q)) |=> irq_n);

    // R1: mask is zero on the first cycle after reset
    a_r1_mask_reset: assert property (@(posedge clk)
        $past(rst) |-> (mask_q == '0) && irq_n);
endmodule

// File: rtl/chg_irq_unit.sv
module chg_irq_unit
    import chg_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_tick,
    input  logic               pin_async,
    input  logic               det_en,
    input  logic               clr_chg,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               mask_wr,
    input  logic [STAT_W-1:0]  mask_wdata,
    output logic [STAT_W-1:0]  status,
    output logic               irq_n,
    output logic               pin_level
);
    logic pin_s;
    logic chg_flag;

    chg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_async),
        .q   (pin_s)
    );

    chg_debounce u_deb (
        .clk   (clk),
        .rst   (rst),
        .tick  (sample_tick),
        .en    (det_en),
        .d     (pin_s),
        .clr   (clr_chg),
        .level (pin_level),
        .chg   (chg_flag)
    );

    always_comb begin
        status                = '0;
        status[NUM_EVT-1:0]   = evt_in;
        status[ST_PIN_CHANGE] = chg_flag;
    end

    chg_irq_ctrl u_irq (
        .clk        (clk),
        .rst        (rst),
        .status     (status),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .irq_n      (irq_n)
    );
endmodule

// File: tb/sim_chg_irq_unit.sv
module sim_chg_irq_unit;
    import chg_irq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_tick = 1'b0;
    logic pin_async = 1'b1;
    logic det_en = 1'b1;
    logic clr_chg = 1'b0;
    logic [NUM_EVT-1:0] evt_in = '0;
    logic mask_wr = 1'b0;
    logic [STAT_W-1:0] mask_wdata = '0;
    logic [STAT_W-1:0] status;
    logic irq_n;
    logic pin_level;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    chg_irq_unit u0 (
        .clk(clk), .rst(rst), .sample_tick(sample_tick), .pin_async(pin_async),
        .det_en(det_en), .clr_chg(clr_chg), .evt_in(evt_in), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .status(status), .irq_n(irq_n), .pin_level(pin_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk) pin_async = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk) sample_tick = 1'b1;
        @(negedge clk) sample_tick = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) clr_chg = 1'b1;
        @(negedge clk) clr_chg = 1'b0;
    endtask

    task automatic sweep(input logic c);
        for (int m = 0; m < (1 << STAT_W); m++) begin
            for (int e = 0; e < (1 << NUM_EVT); e++) begin
                logic [STAT_W-1:0] exp_st;
                @(negedge clk);
                mask_wr = 1'b1; mask_wdata = m[STAT_W-1:0]; evt_in = e[NUM_EVT-1:0];
                @(negedge clk) mask_wr = 1'b0;
                @(negedge clk);
                exp_st = {c, e[NUM_EVT-1:0]};
                chk("R8 status", 32'(status), 32'(exp_st));
                chk("R9 irq_n", 32'(irq_n), 32'(!(|(exp_st & m[STAT_W-1:0]))));
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_n", 32'(irq_n), 1);
        chk("R1 change flag", 32'(status[ST_PIN_CHANGE]), 0);
        chk("R1 pin_level", 32'(pin_level), 1);
        evt_in = '1;
        repeat (2) @(negedge clk);
        chk("R1 mask zero", 32'(irq_n), 1);
        evt_in = '0;

        // R2 falling, no acceptance without ticks
        set_pin(1'b0);
        repeat (20) @(negedge clk);
        chk("R2 no tick level", 32'(pin_level), 1);
        chk("R2 no tick flag", 32'(status[ST_PIN_CHANGE]), 0);
        pulse_tick();
        chk("R2 first tick flag", 32'(status[ST_PIN_CHANGE]), 0);
        chk("R2 first tick level", 32'(pin_level), 1);
        pulse_tick();
        chk("R2 second tick flag", 32'(status[ST_PIN_CHANGE]), 1);
        chk("R2 second tick level", 32'(pin_level), 0);

        // R5 hold then clear
        repeat (10) @(negedge clk);
        chk("R5 hold", 32'(status[ST_PIN_CHANGE]), 1);
        clear_flag();
        chk("R5 cleared", 32'(status[ST_PIN_CHANGE]), 0);

        // R3 rising
        set_pin(1'b1);
        pulse_tick();
        chk("R3 first tick flag", 32'(status[ST_PIN_CHANGE]), 0);
        pulse_tick();
        chk("R3 flag", 32'(status[ST_PIN_CHANGE]), 1);
        chk("R3 level", 32'(pin_level), 1);
        clear_flag();

        // R4 single-sample glitch
        set_pin(1'b0);
        pulse_tick();
        set_pin(1'b1);
        pulse_tick();
        chk("R4 flag", 32'(status[ST_PIN_CHANGE]), 0);
        chk("R4 level", 32'(pin_level), 1);
        pulse_tick();
        chk("R4 flag later", 32'(status[ST_PIN_CHANGE]), 0);

        // R6 set beats clear
        set_pin(1'b0);
        pulse_tick();
        @(negedge clk) begin sample_tick = 1'b1; clr_chg = 1'b1; end
        @(negedge clk) begin sample_tick = 1'b0; clr_chg = 1'b0; end
        chk("R6 flag", 32'(status[ST_PIN_CHANGE]), 1);
        chk("R6 level", 32'(pin_level), 0);
        clear_flag();

        // R7 disabled detector
        det_en = 1'b0;
        set_pin(1'b1);
        pulse_tick();
        pulse_tick();
        chk("R7 flag disabled", 32'(status[ST_PIN_CHANGE]), 0);
        chk("R7 level tracks", 32'(pin_level), 1);
        @(negedge clk) det_en = 1'b1;
        pulse_tick();
        pulse_tick();
        chk("R7 no stale event", 32'(status[ST_PIN_CHANGE]), 0);

        // R8/R9 exhaustive sweep, flag clear
        sweep(1'b0);

        // R9 registered lag probe
        @(negedge clk) begin mask_wr = 1'b1; mask_wdata = '1; evt_in = '0; end
        @(negedge clk) mask_wr = 1'b0;
        @(negedge clk);
        chk("R9 idle", 32'(irq_n), 1);
        evt_in[ST_CNT_READY] = 1'b1;
        #1;
        chk("R9 lag", 32'(irq_n), 1);
        @(negedge clk);
        chk("R9 asserted", 32'(irq_n), 0);
        evt_in = '0;

        // R8/R9 sweep with the change flag set
        set_pin(1'b0);
        pulse_tick();
        pulse_tick();
        chk("R2 flag for sweep", 32'(status[ST_PIN_CHANGE]), 1);
        sweep(1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule